// File: doc/BRIEF.md
# Difference-Cut Threshold Neuron

This block evaluates a single threshold neuron over a vector of unsigned operands, where each operand is an already formed weight-times-input product. It uses no adder tree. It treats the operand vector as a cut. In every processing cycle it takes the smallest nonzero value in the cut and subtracts it from every nonzero element. It then adds that minimum, scaled by the number of elements that were still nonzero, to a running sum.

The running sum is compared with the threshold before each step. The neuron fires as soon as the sum reaches the threshold, so a low threshold gives a fast answer. If every element reaches zero first, the neuron stays silent. Elements with equal values vanish in the same step, so the number of steps equals the number of distinct nonzero operand values, and it is never more than the operand count.

A client drives the operands and the threshold in parallel and pulses start. It then waits for a one-cycle done pulse, which marks the binary output, the accumulated sum and the step count as valid.

Top module: `dcut_neuron`

## Requirements
- R1: After reset, busy_o and done_o are low. A start_i pulse while busy_o is low captures ops_i and thr_i, and busy_o is high in the next cycle.
- R2: start_i is ignored while busy_o is high. The result reported is the one for the operands and threshold captured at the accepted start.
- R3: Each step subtracts the smallest nonzero element from every nonzero element. When the threshold is not reached, the reported step count equals the number of distinct nonzero operand values.
- R4: Each step adds (minimum × number of nonzero elements) to the sum. With no early stop, sum_o equals the exact sum of all operands, including N_OPS operands at the maximum value, without overflow.
- R5: The reported step count never exceeds N_OPS. N_OPS distinct nonzero operands take exactly N_OPS steps.
- R6: Before each step, the block compares the sum with the threshold as unsigned values. If sum ≥ threshold, it finishes with fire_o = 1. sum_o and cycles_o then hold the sum and the step count reached at that point.
- R7: If all elements reach zero while the sum is still below the threshold, the block finishes with fire_o = 0.
- R8: An all-zero operand vector finishes with 0 steps and sum 0. fire_o is 1 only when the threshold is 0.
- R9: done_o is high for exactly one cycle, in the first cycle with busy_o low. busy_o stays high for (steps + 1) cycles after the load edge.
- R10: A threshold of 0 with nonzero operands fires with 0 steps and sum 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| ops_i | input | N_OPS*OP_W | Operand vector; element k occupies bits [k*OP_W +: OP_W] |
| thr_i | input | SUM_W | Unsigned threshold |
| busy_o | output | 1 | Evaluation in progress |
| done_o | output | 1 | One-cycle pulse marking valid results |
| fire_o | output | 1 | Neuron output (1 = threshold reached) |
| sum_o | output | SUM_W | Accumulated sum |
| cycles_o | output | CNT_W | Number of subtract steps performed |

## Verification
The bound checker checks four properties on every cycle. First, done is a single-cycle pulse that only appears with busy low. Second, busy can fall only through done. Third, the sum never decreases and the step count rises by at most one per cycle during a run. Fourth, a run that reports zero steps reports a zero sum, and no run reports more than N_OPS steps. Only the bench scenarios can show that the values are correct: the exact totals, the step count tracking distinct values, the early firing point, the all-zero and zero-threshold cases, and the start pulse that is ignored while busy.

// File: rtl/dcut_pkg.sv
`timescale 1ns/1ps
package dcut_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } dcut_phase_e;
endpackage

// File: rtl/dcut_lane.sv
`timescale 1ns/1ps
// One element of the cut: load, or reduce by the step minimum while nonzero.
module dcut_lane #(
    parameter int OP_W = 16
) (
    input  logic [OP_W-1:0] cur_i,
    input  logic [OP_W-1:0] load_val_i,
    input  logic            load_i,
    input  logic            sub_i,
    input  logic [OP_W-1:0] step_min_i,
    output logic [OP_W-1:0] nxt_o,
    output logic            act_o
);
    always_comb begin
        act_o = (cur_i != '0);
        if (load_i) begin
            nxt_o = load_val_i;
        end else if (sub_i && act_o) begin
            nxt_o = cur_i - step_min_i;
        end else begin
            nxt_o = cur_i;
        end
    end
endmodule

// File: rtl/dcut_min_scan.sv
`timescale 1ns/1ps
// Smallest nonzero element and count of nonzero elements.
module dcut_min_scan #(
    parameter int N_OPS = 8,
    parameter int OP_W  = 16,
    parameter int CNT_W = $clog2(N_OPS + 1)
) (
    input  logic [N_OPS-1:0][OP_W-1:0] vals_i,
    input  logic [N_OPS-1:0]           act_i,
    output logic [OP_W-1:0]            min_o,
    output logic [CNT_W-1:0]           cnt_o
);
    always_comb begin
        min_o = '1;
        cnt_o = '0;
        for (int i = 0; i < N_OPS; i++) begin
            if (act_i[i]) begin
                if (vals_i[i] < min_o) begin
                    min_o = vals_i[i];
                end
                cnt_o = cnt_o + CNT_W'(1);
            end
        end
    end
endmodule

// File: rtl/dcut_scale.sv
`timescale 1ns/1ps
// Partial sum of one step: minimum times active count.
module dcut_scale #(
    parameter int OP_W  = 16,
    parameter int CNT_W = 4,
    parameter int SUM_W = 19
) (
    input  logic [OP_W-1:0]  min_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic [SUM_W-1:0] part_o
);
    always_comb begin
        part_o = SUM_W'(min_i) * SUM_W'(cnt_i);
    end
endmodule

// File: rtl/dcut_neuron.sv
`timescale 1ns/1ps
module dcut_neuron #(
    parameter int N_OPS = 8,
    parameter int OP_W  = 16,
    parameter int SUM_W = OP_W + $clog2(N_OPS),
    parameter int CNT_W = $clog2(N_OPS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_i,
    input  logic [N_OPS*OP_W-1:0]   ops_i,
    input  logic [SUM_W-1:0]        thr_i,
    output logic                    busy_o,
    output logic                    done_o,
    output logic                    fire_o,
    output logic [SUM_W-1:0]        sum_o,
    output logic [CNT_W-1:0]        cycles_o
);
    import dcut_pkg::*;

    typedef struct packed {
        dcut_phase_e                 phase;
        logic [N_OPS-1:0][OP_W-1:0]  cut;
        logic [SUM_W-1:0]            thr;
        logic [SUM_W-1:0]            sum;
        logic [CNT_W-1:0]            cnt;
        logic                        fire;
        logic                        done;
    } dcut_state_t;

    dcut_state_t st_d, st_q;

    logic                        lane_load;
    logic                        lane_sub;
    logic [N_OPS-1:0][OP_W-1:0]  lane_nxt;
    logic [N_OPS-1:0]            lane_act;
    logic [OP_W-1:0]             step_min;
    logic [CNT_W-1:0]            step_cnt;
    logic [SUM_W-1:0]            step_part;

    for (genvar k = 0; k < N_OPS; k++) begin : g_lane
        dcut_lane #(.OP_W(OP_W)) u_lane (
            .cur_i      (st_q.cut[k]),
            .load_val_i (ops_i[k*OP_W +: OP_W]),
            .load_i     (lane_load),
            .sub_i      (lane_sub),
            .step_min_i (step_min),
            .nxt_o      (lane_nxt[k]),
            .act_o      (lane_act[k])
        );
    end

    dcut_min_scan #(.N_OPS(N_OPS), .OP_W(OP_W), .CNT_W(CNT_W)) u_scan (
        .vals_i (st_q.cut),
        .act_i  (lane_act),
        .min_o  (step_min),
        .cnt_o  (step_cnt)
    );

    dcut_scale #(.OP_W(OP_W), .CNT_W(CNT_W), .SUM_W(SUM_W)) u_scale (
        .min_i  (step_min),
        .cnt_i  (step_cnt),
        .part_o (step_part)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        lane_load = 1'b0;
        lane_sub  = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    lane_load  = 1'b1;
                    st_d.phase = PH_RUN;
                    st_d.thr   = thr_i;
                    st_d.sum   = '0;
                    st_d.cnt   = '0;
                    st_d.fire  = 1'b0;
                end
            end
            PH_RUN: begin
                if (st_q.sum >= st_q.thr) begin
                    st_d.phase = PH_IDLE;
                    st_d.fire  = 1'b1;
                    st_d.done  = 1'b1;
                end else if (step_cnt == '0) begin
                    st_d.phase = PH_IDLE;
                    st_d.fire  = 1'b0;
                    st_d.done  = 1'b1;
                end else begin
                    lane_sub = 1'b1;
                    st_d.sum = st_q.sum + step_part;
                    st_d.cnt = st_q.cnt + CNT_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
        st_d.cut = lane_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o   = (st_q.phase == PH_RUN);
    assign done_o   = st_q.done;
    assign fire_o   = st_q.fire;
    assign sum_o    = st_q.sum;
    assign cycles_o = st_q.cnt;
endmodule

// File: rtl/dcut_neuron_chk.sv
`timescale 1ns/1ps
module dcut_neuron_chk #(
    parameter int N_OPS = 8,
    parameter int SUM_W = 19,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [SUM_W-1:0] sum_o,
    input logic [CNT_W-1:0] cycles_o
);
    a_r1_start_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    a_r9_busy_exit: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

    a_r4_sum_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> (sum_o >= $past(sum_o)));

    a_r3_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |->
        (({1'b0, cycles_o} == {1'b0, $past(cycles_o)}) ||
         ({1'b0, cycles_o} == ({1'b0, $past(cycles_o)} + 1'b1))));

    a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (int'(cycles_o) <= N_OPS));

    a_r8_zero_steps_zero_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && cycles_o == '0) |-> (sum_o == '0));
endmodule

bind dcut_neuron dcut_neuron_chk #(
    .N_OPS(N_OPS), .SUM_W(SUM_W), .CNT_W(CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .busy_o   (busy_o),
    .done_o   (done_o),
    .sum_o    (sum_o),
    .cycles_o (cycles_o)
);

// File: tb/test_dcut_neuron.sv
`timescale 1ns/1ps
module test_dcut_neuron;
    localparam int N  = 8;
    localparam int W  = 16;
    localparam int SW = W + $clog2(N);
    localparam int CW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [N*W-1:0] ops_i = '0;
    logic [SW-1:0] thr_i = '0;
    logic          busy_o, done_o, fire_o;
    logic [SW-1:0] sum_o;
    logic [CW-1:0] cycles_o;

    always #10 clk = ~clk;

    dcut_neuron #(.N_OPS(N), .OP_W(W)) i_dcut_neuron (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .ops_i(ops_i), .thr_i(thr_i),
        .busy_o(busy_o), .done_o(done_o), .fire_o(fire_o), .sum_o(sum_o), .cycles_o(cycles_o)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // behavioural reference
    int     m_ops[N];
    longint m_sum, m_thr;
    int     m_cnt;
    bit     m_busy, m_done, m_fire;

    task automatic chk(input string tag, input longint act, input longint exp, input string what);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step();
        int q, b;
        m_done = 0;
        if (!m_busy) begin
            if (start_i) begin
                for (int k = 0; k < N; k++) m_ops[k] = int'(ops_i[k*W +: W]);
                m_thr = longint'(thr_i);
                m_sum = 0; m_cnt = 0; m_fire = 0; m_busy = 1;
            end
        end else if (m_sum >= m_thr) begin
            m_busy = 0; m_done = 1; m_fire = 1;
        end else begin
            q = -1; b = 0;
            for (int k = 0; k < N; k++)
                if (m_ops[k] != 0) begin
                    b++;
                    if (q < 0 || m_ops[k] < q) q = m_ops[k];
                end
            if (b == 0) begin
                m_busy = 0; m_done = 1; m_fire = 0;
            end else begin
                for (int k = 0; k < N; k++) if (m_ops[k] != 0) m_ops[k] -= q;
                m_sum += longint'(q) * b;
                m_cnt++;
            end
        end
    endtask

    task automatic compare_all();
        chk("R9", busy_o, m_busy, "busy");
        chk("R9", done_o, m_done, "done");
        if (m_done) begin
            chk("R6", fire_o, m_fire, "model fire");
            chk("R4", sum_o, m_sum, "model sum");
            chk("R5", cycles_o, m_cnt, "model cycles");
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive(input int v[N], input longint thr);
        for (int k = 0; k < N; k++) ops_i[k*W +: W] = W'(v[k]);
        thr_i = SW'(thr);
    endtask

    task automatic run(input int v[N], input longint thr, input bit e_fire,
                       input longint e_sum, input int e_cyc, input string tag);
        int lat;
        bit got;
        drive(v, thr);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        lat = 0; got = 0;
        while (!got && lat < 60) begin
            tick();
            lat++;
            if (done_o) begin
                got = 1;
                chk(tag, fire_o, e_fire, "fire");
                chk(tag, sum_o, e_sum, "sum");
                chk(tag, cycles_o, e_cyc, "cycles");
                chk("R9", lat, e_cyc + 1, "latency");
            end
        end
        if (!got) chk("R9", 0, 1, "run watchdog");
        tick();
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int lat;
        bit got;
        m_busy = 0; m_done = 0; m_fire = 0; m_sum = 0; m_cnt = 0; m_thr = 0;
        repeat (3) @(negedge clk);
        chk("R1", busy_o, 0, "reset busy");
        chk("R1", done_o, 0, "reset done");
        rst_n = 1'b1;
        tick();

        // R3 R4 R7: four distinct values, threshold never met
        run('{5, 3, 5, 3, 0, 7, 7, 1}, 1000, 0, 31, 4, "R3");
        // R6: early firing after the third step (7, 19, 27)
        run('{5, 3, 5, 3, 0, 7, 7, 1}, 20, 1, 27, 3, "R6");
        // R7: threshold one above the total
        run('{2, 2, 4, 0, 0, 0, 0, 1}, 10, 0, 9, 3, "R7");
        // R8: all-zero operands
        run('{0, 0, 0, 0, 0, 0, 0, 0}, 0, 1, 0, 0, "R8");
        run('{0, 0, 0, 0, 0, 0, 0, 0}, 5, 0, 0, 0, "R8");
        // R10: zero threshold with nonzero operands
        run('{9, 8, 7, 6, 5, 4, 3, 2}, 0, 1, 0, 0, "R10");
        // R4: all maximum values, one step, no overflow
        run('{65535, 65535, 65535, 65535, 65535, 65535, 65535, 65535},
            524287, 0, 524280, 1, "R4");
        // R5: distinct values need N steps, fires exactly at the total
        run('{8, 1, 7, 2, 6, 3, 5, 4}, 36, 1, 36, 8, "R5");

        // R2: a second start during the run is ignored
        drive('{5, 3, 5, 3, 0, 7, 7, 1}, 1000);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        tick();
        drive('{9, 9, 9, 9, 9, 9, 9, 9}, 0);
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
        lat = 2; got = 0;
        while (!got && lat < 60) begin
            tick();
            lat++;
            if (done_o) begin
                got = 1;
                chk("R2", fire_o, 0, "fire");
                chk("R2", sum_o, 31, "sum");
                chk("R2", cycles_o, 4, "cycles");
            end
        end
        if (!got) chk("R2", 0, 1, "run watchdog");
        tick();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule